// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

A synchronous binary up-counter, four bits wide by default, whose state bits all change together on the rising clock edge. A parallel preset can set it to any value, and an active-low clear returns it to zero. It has two count enables, each with its own role. Enable P only gates counting. Enable T gates counting and also qualifies the carry output.

Stages are chained with no glue logic. Each stage's carry drives the enable T of the next stage, and one enable P is shared by all stages. A build-time parameter sets the clear to act at once, without a clock edge, or at the next rising edge. The synchronous form lets a decode of a chosen terminal count shorten the counting cycle. An active-high synchronous reset stands for the power-up clear.

When several controls are active at the same edge, clear wins over load, and load wins over counting.

Top module: `presettable_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `q` becomes zero at that edge. This holds in both clear modes.
- R2: At a rising edge with `clr_n` high, `load_n` high, `en_p` high and `en_t` high, `q` becomes `q+1`, taken modulo 2^WIDTH, so that all ones wraps to zero.
- R3: At a rising edge with `clr_n` and `load_n` high and either enable low, `q` keeps its value.
- R4: At a rising edge with `clr_n` high and `load_n` low, `q` takes `din`, whatever the levels of `en_p` and `en_t`.
- R5: With CLR_MODE = CLR_ASYNC, a low `clr_n` drives `q` to zero without waiting for a clock edge. It overrides load and both enables.
- R6: With CLR_MODE = CLR_SYNC, a low `clr_n` leaves `q` unchanged until the next rising edge. At that edge `q` becomes zero, overriding load and both enables.
- R7: `carry` is high exactly when `en_t` is high and `q` is all ones. It follows `en_t` and `q` without a clock edge. `en_p` has no effect on it.
- R8: Two stages wired with the low stage's `carry` on the high stage's `en_t` and a common `en_p` count as one 2·WIDTH-bit counter. The value is {high q, low q}, and it wraps from all ones to zero.
- R9: A change of `load_n`, `en_p`, `en_t` or `din` between edges does not change `q` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset (power-up clear) |
| clr_n | input | 1 | Active-low clear; timing set by CLR_MODE |
| load_n | input | 1 | Active-low synchronous parallel preset |
| en_p | input | 1 | Count enable that gates counting only |
| en_t | input | 1 | Count enable that also qualifies the carry |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Count value |
| carry | output | 1 | High when en_t is high and q is all ones |

## Verification
Every start value is loaded and then combined with all sixteen settings of clear, load and the two enables. The same stimulus runs against an asynchronous-clear instance and a synchronous-clear instance. A swapped priority would show here as a load winning over a clear, or a count winning over a load. Carry is checked between edges, so a carry that also depended on `en_p`, or one that waited for a clock edge, would give the wrong level. The output is also compared just after each clear is driven, to catch an asynchronous clear that waits for the edge and a synchronous clear that acts early. A two-stage chain runs across several full wraps to show that the upper stage steps only on the lower stage's terminal count.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;

    typedef enum logic {
        CLR_ASYNC = 1'b0,
        CLR_SYNC  = 1'b1
    } clr_mode_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic en_p;
        logic en_t;
    } cnt_ctl_t;

    // fixed priority: clear, then load, then count, else hold
    function automatic cnt_op_e pick_op(cnt_ctl_t c);
        if (!c.clr_n)            return OP_CLEAR;
        else if (!c.load_n)      return OP_LOAD;
        else if (c.en_p && c.en_t) return OP_COUNT;
        else                     return OP_HOLD;
    endfunction

endpackage

// File: rtl/cnt_decode.sv
`timescale 1ns/1ps
module cnt_decode
    import cnt_pkg::*;
(
    input  cnt_ctl_t ctl,
    output cnt_op_e  op
);

    always_comb begin
        op = pick_op(ctl);
    end

endmodule

// File: rtl/cnt_next.sv
`timescale 1ns/1ps
module cnt_next
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = cur + ONE;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_carry.sv
`timescale 1ns/1ps
module cnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_t,
    output logic             carry
);

    localparam logic [WIDTH-1:0] TERMINAL = {WIDTH{1'b1}};

    assign carry = en_t && (cur == TERMINAL);

endmodule

// File: rtl/presettable_counter.sv
`timescale 1ns/1ps
module presettable_counter
    import cnt_pkg::*;
#(
    parameter int        WIDTH    = 4,
    parameter clr_mode_e CLR_MODE = CLR_ASYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry
);

    cnt_ctl_t         ctl;
    cnt_op_e          op;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    assign ctl = '{clr_n: clr_n, load_n: load_n, en_p: en_p, en_t: en_t};

    cnt_decode u_decode (
        .ctl (ctl),
        .op  (op)
    );

    cnt_next #(.WIDTH(WIDTH)) u_next (
        .op  (op),
        .cur (state_q),
        .din (din),
        .nxt (state_d)
    );

    cnt_carry #(.WIDTH(WIDTH)) u_carry (
        .cur   (state_q),
        .en_t  (en_t),
        .carry (carry)
    );

    generate
        if (CLR_MODE == CLR_ASYNC) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)   state_q <= '0;
                else if (rst) state_q <= '0;
                else          state_q <= state_d;
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                if (rst) state_q <= '0;
                else     state_q <= state_d;
            end
        end
    endgenerate

    assign q = state_q;

endmodule

// File: rtl/counter_chk.sv
`timescale 1ns/1ps
module counter_chk
    import cnt_pkg::*;
#(
    parameter int        WIDTH    = 4,
    parameter clr_mode_e CLR_MODE = CLR_ASYNC
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_n,
    input logic             load_n,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             carry
);

    localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};
    localparam bit IS_ASYNC = (CLR_MODE == CLR_ASYNC);

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> q == '0);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && en_p && en_t)
        |=> ((IS_ASYNC && !clr_n) || q == $past(q) + WIDTH'(1)));

    // R3
    hold_value_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && !(en_p && en_t))
        |=> ((IS_ASYNC && !clr_n) || $stable(q)));

    // R4
    preset_take_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !load_n)
        |=> ((IS_ASYNC && !clr_n) || q == $past(din)));

    // R5
    async_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (IS_ASYNC && !clr_n) |-> q == '0);

    // R6
    sync_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!IS_ASYNC && !clr_n) |=> q == '0);

    // R7
    carry_low_chk: assert property (@(posedge clk) disable iff (rst)
        !(en_t && q == ALL1) |-> !carry);

    // R7
    carry_high_chk: assert property (@(posedge clk) disable iff (rst)
        (en_t && q == ALL1) |-> carry);

endmodule

bind presettable_counter counter_chk #(.WIDTH(WIDTH), .CLR_MODE(CLR_MODE)) u_chk (.*);

// File: tb/test_presettable_counter.sv
`timescale 1ns/1ps
module test_presettable_counter;
    import cnt_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // shared stimulus for the async and sync single stages
    logic       rst = 1'b1;
    logic       clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
    logic [3:0] din = '0;
    logic [3:0] qa, qs;
    logic       ca, cs;
    logic [3:0] ea = '0, es = '0;

    // cascade stimulus
    logic       k_clr_n = 1'b1, k_load_n = 1'b1, k_p = 1'b0, k_t = 1'b0;
    logic [7:0] k_din = '0;
    logic [3:0] ql, qh;
    logic       cl, ch;
    logic [7:0] e8 = '0;

    presettable_counter #(.WIDTH(4), .CLR_MODE(CLR_ASYNC)) i_presettable_counter (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
        .en_t(en_t), .din(din), .q(qa), .carry(ca));

    presettable_counter #(.WIDTH(4), .CLR_MODE(CLR_SYNC)) i_sync (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
        .en_t(en_t), .din(din), .q(qs), .carry(cs));

    presettable_counter #(.WIDTH(4), .CLR_MODE(CLR_SYNC)) i_lo (
        .clk(clk), .rst(rst), .clr_n(k_clr_n), .load_n(k_load_n), .en_p(k_p),
        .en_t(k_t), .din(k_din[3:0]), .q(ql), .carry(cl));

    presettable_counter #(.WIDTH(4), .CLR_MODE(CLR_SYNC)) i_hi (
        .clk(clk), .rst(rst), .clr_n(k_clr_n), .load_n(k_load_n), .en_p(k_p),
        .en_t(cl), .din(k_din[7:4]), .q(qh), .carry(ch));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] model(input logic [3:0] cur, input logic c_n,
                                         input logic l_n, input logic p, input logic t,
                                         input logic [3:0] d);
        if (!c_n)       return 4'd0;
        else if (!l_n)  return d;
        else if (p && t) return cur + 4'd1;
        else            return cur;
    endfunction

    task automatic step(input logic c_n, input logic l_n, input logic p,
                        input logic t, input logic [3:0] d);
        @(negedge clk);
        clr_n = c_n; load_n = l_n; en_p = p; en_t = t; din = d;
        #1;
        if (!c_n) begin
            ea = 4'd0;
            chk(qa == 4'd0, "R5 async clear without edge", qa, 0);
            chk(qs == es, "R6 sync clear waits for edge", qs, es);
        end else begin
            chk(qa == ea, "R9 async stage stable between edges", qa, ea);
            chk(qs == es, "R9 sync stage stable between edges", qs, es);
        end
        chk(ca == (t && ea == 4'hF), "R7 carry async stage", ca, t && ea == 4'hF);
        chk(cs == (t && es == 4'hF), "R7 carry sync stage", cs, t && es == 4'hF);
        ea = model(ea, c_n, l_n, p, t, d);
        es = model(es, c_n, l_n, p, t, d);
        @(posedge clk);
        #1;
        chk(qa == ea, !c_n ? "R5" : (!l_n ? "R4" : ((p && t) ? "R2" : "R3")), qa, ea);
        chk(qs == es, !c_n ? "R6" : (!l_n ? "R4" : ((p && t) ? "R2" : "R3")), qs, es);
    endtask

    task automatic kstep(input logic c_n, input logic l_n, input logic p,
                         input logic t, input logic [7:0] d);
        @(negedge clk);
        k_clr_n = c_n; k_load_n = l_n; k_p = p; k_t = t; k_din = d;
        #1;
        chk(cl == (t && e8[3:0] == 4'hF), "R8 low stage carry", cl, t && e8[3:0] == 4'hF);
        chk(ch == (t && e8 == 8'hFF), "R8 chain carry", ch, t && e8 == 8'hFF);
        if (!c_n)       e8 = 8'd0;
        else if (!l_n)  e8 = d;
        else if (p && t) e8 = e8 + 8'd1;
        @(posedge clk);
        #1;
        chk({qh, ql} == e8, "R8 chained value", {qh, ql}, e8);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        chk(qa == 4'd0, "R1 reset async stage", qa, 0);
        chk(qs == 4'd0, "R1 reset sync stage", qs, 0);
        chk({qh, ql} == 8'd0, "R1 reset chain", {qh, ql}, 0);
        @(negedge clk);
        rst = 1'b0;

        // exhaustive: every start value against every control combination
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                step(1'b1, 1'b0, 1'b0, 1'b0, 4'(s));
                step(c[3], c[2], c[1], c[0], 4'(s * 7 + 3));
            end
        end

        // R2: full run of counting with explicit wrap
        step(1'b1, 1'b0, 1'b1, 1'b1, 4'd12);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 4'd5);

        // R7: en_p has no effect on carry at all ones
        step(1'b1, 1'b0, 1'b0, 1'b1, 4'hF);
        step(1'b1, 1'b1, 1'b0, 1'b1, 4'h0);
        step(1'b1, 1'b1, 1'b1, 1'b0, 4'h0);

        // R8: cascade
        kstep(1'b1, 1'b0, 1'b0, 1'b0, 8'hF0);
        for (int i = 0; i < 40; i++) kstep(1'b1, 1'b1, (i % 7) != 3, 1'b1, 8'h00);
        kstep(1'b1, 1'b0, 1'b1, 1'b1, 8'h0D);
        for (int i = 0; i < 530; i++) kstep(1'b1, 1'b1, 1'b1, 1'b1, 8'h55);
        for (int i = 0; i < 5; i++) kstep(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        kstep(1'b0, 1'b0, 1'b1, 1'b1, 8'hAA);
        kstep(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
        kstep(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule